// File: doc/BRIEF.md
# Lock-aware fully associative translation buffer

This block holds up to 64 address translations in a fully associative array. Each slot keeps a page-aligned virtual address, a partition number, a context number, a real-mode flag, a page size code and a 64-bit translation word. Bit 6 of that word marks the translation as locked. A command port changes the contents. It can insert a translation, into a named slot or into a slot the block picks. It can remove one page, everything in a context, the unlocked entries of a partition, or every entry. Every accepted command raises a one-cycle pulse, so that any small translation caches further down the path can flush themselves.

A lookup port compares an address against all slots in the same cycle. It returns a hit vector, a hit flag and the translation word. A diagnostic port reads back one slot by index: a packed tag word, the translation word and the slot's used bit.

When the block picks the slot itself, it takes a free slot first. If there is none, it steps round-robin past locked slots. Used bits age together once every slot has been marked used.

Top module: `lockaware_xlate_buf`

## Requirements
- R1: After reset every slot is invalid, the lookup reports no hit, `cmd_ready` is 1 and `inval_pulse` is 0.
- R2: Op codes: 0 insert, 1 demap page, 2 demap context, 3 demap partition, 4 invalidate all. An insert without `cmd_slot_en` writes the lowest-index invalid slot and marks it valid and used.
- R3: Before any insert, a valid slot whose address, size, partition, context and real flag all equal the new ones is invalidated. That slot then counts as free.
- R4: An insert with `cmd_slot_en` set writes slot `cmd_slot`, whatever that slot holds.
- R5: An automatic insert with no free slot searches from one past the last replaced index, wrapping at N. It skips slots whose translation word has bit 6 set. The chosen slot becomes the last replaced index. Explicit-slot inserts and free-slot inserts leave that index unchanged. The index is 0 after reset.
- R6: If the search finds no unlocked slot other than the last replaced one, slot N-1 is overwritten and the last replaced index is kept.
- R7: When an insert leaves N used bits set, the used bits of all unlocked slots are cleared. Locked slots keep theirs.
- R8: A slot hits a lookup when it is valid and its partition and real flag are equal to the lookup's. Its context must also be equal, unless the real flag is 1. The address must also fall inside the page: the page spans 8 KiB shifted left by three times the size code. `lk_data` is the translation word of the hit slot.
- R9: A demap-page command invalidates every slot that a lookup with the same address, partition, context and real flag would hit.
- R10: Demap-context invalidates every slot of that partition and context, locked or not. Demap-partition invalidates only the unlocked slots of that partition. Invalidate-all clears every slot.
- R11: A diagnostic read of a valid slot gives the tag word {partition[63:61], real[60], 0[59], inverted size[58:56], address OR context[55:0]}. For an invalid slot the tag and data words are all ones and the used bit is 0.
- R12: Each accepted command with op 0 to 4 raises `inval_pulse` for exactly the next cycle. Op codes 5 to 7 change nothing and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command port can accept |
| cmd_op | input | 3 | Operation code |
| cmd_va | input | 56 | Page-aligned virtual address |
| cmd_part | input | 3 | Partition number |
| cmd_ctx | input | 13 | Context number |
| cmd_real | input | 1 | Real-mode flag |
| cmd_size | input | 3 | Page size code |
| cmd_data | input | 64 | Translation word, bit 6 is the lock |
| cmd_slot_en | input | 1 | Use the explicit slot index |
| cmd_slot | input | IW | Explicit slot index |
| lk_va | input | 56 | Lookup address |
| lk_part | input | 3 | Lookup partition |
| lk_ctx | input | 13 | Lookup context |
| lk_real | input | 1 | Lookup real-mode flag |
| lk_hit | output | 1 | Some slot matches |
| lk_hit_vec | output | N | Matching slots |
| lk_data | output | 64 | Translation word of the matching slot |
| dg_idx | input | IW | Diagnostic slot index |
| dg_tag | output | 64 | Packed tag word of that slot |
| dg_data | output | 64 | Translation word of that slot |
| dg_used | output | 1 | Used bit of that slot |
| inval_pulse | output | 1 | Downstream flush request |

## Verification
A command is registered on the edge that accepts it. Lookup and diagnostic results therefore reflect it from that edge onward, with no further latency. `inval_pulse` is high for the one cycle that follows that edge. The bench drives each command at a falling edge and removes it at the next falling edge. At that same point it reads the pulse and the combinational lookup and diagnostic outputs, and one falling edge later it reads the pulse again to confirm it has dropped. The scenarios set the last replaced index and the lock bits up front, so the expected victim slot is known before each automatic insert.

// File: rtl/lockaware_xlate_buf.sv
module lockaware_xlate_buf #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [55:0]   cmd_va,
  input  logic [2:0]    cmd_part,
  input  logic [12:0]   cmd_ctx,
  input  logic          cmd_real,
  input  logic [2:0]    cmd_size,
  input  logic [63:0]   cmd_data,
  input  logic          cmd_slot_en,
  input  logic [IW-1:0] cmd_slot,
  input  logic [55:0]   lk_va,
  input  logic [2:0]    lk_part,
  input  logic [12:0]   lk_ctx,
  input  logic          lk_real,
  output logic          lk_hit,
  output logic [N-1:0]  lk_hit_vec,
  output logic [63:0]   lk_data,
  input  logic [IW-1:0] dg_idx,
  output logic [63:0]   dg_tag,
  output logic [63:0]   dg_data,
  output logic          dg_used,
  output logic          inval_pulse
);
  localparam int LOCK_BIT = 6;
  localparam logic [2:0] OP_INS = 3'd0, OP_DPG = 3'd1, OP_DCX = 3'd2,
                         OP_DPT = 3'd3, OP_INV = 3'd4;

  logic [55:0] e_va   [N];
  logic [2:0]  e_part [N];
  logic [12:0] e_ctx  [N];
  logic        e_real [N];
  logic [2:0]  e_sz   [N];
  logic [63:0] e_data [N];

  logic [N-1:0]  valid_q, used_q, valid_n, used_n;
  logic [N-1:0]  lock_v, lock_n, cf_vec, pg_vec, cx_vec, pt_vec;
  logic [IW-1:0] last_q, free_idx, rr_idx, ins_slot;
  logic          rdy_q, inval_q, any_free, rr_found, slot_ok, acc;

  function automatic logic in_page(input logic [55:0] base, input logic [55:0] a,
                                   input logic [2:0] sz);
    logic [55:0] m;
    m = {56{1'b1}} << (13 + 3 * int'(sz));
    return ((base ^ a) & m) == '0;
  endfunction

  assign cmd_ready   = rdy_q;
  assign inval_pulse = inval_q;
  assign acc         = cmd_valid && rdy_q;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign lock_v[i] = e_data[i][LOCK_BIT];
    assign lk_hit_vec[i] = valid_q[i] && e_part[i] == lk_part && e_real[i] == lk_real &&
                           (lk_real || e_ctx[i] == lk_ctx) && in_page(e_va[i], lk_va, e_sz[i]);
    assign pg_vec[i] = valid_q[i] && e_part[i] == cmd_part && e_real[i] == cmd_real &&
                       (cmd_real || e_ctx[i] == cmd_ctx) && in_page(e_va[i], cmd_va, e_sz[i]);
    assign cf_vec[i] = valid_q[i] && e_va[i] == cmd_va && e_sz[i] == cmd_size &&
                       e_part[i] == cmd_part && e_ctx[i] == cmd_ctx && e_real[i] == cmd_real;
    assign cx_vec[i] = valid_q[i] && e_part[i] == cmd_part && e_ctx[i] == cmd_ctx;
    assign pt_vec[i] = valid_q[i] && e_part[i] == cmd_part && !lock_v[i];
  end

  assign lk_hit = |lk_hit_vec;

  always_comb begin
    lk_data = '0;
    for (int i = 0; i < N; i++)
      if (lk_hit_vec[i]) lk_data = lk_data | e_data[i];
  end

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!valid_q[i] || cf_vec[i]) begin
        any_free = 1'b1;
        free_idx = IW'(i);
      end
  end

  always_comb begin
    rr_found = 1'b0;
    rr_idx   = IW'(N - 1);
    for (int k = 1; k < N; k++) begin
      int j;
      j = int'(last_q) + k;
      if (j >= N) j = j - N;
      if (!rr_found && !lock_v[j]) begin
        rr_found = 1'b1;
        rr_idx   = IW'(j);
      end
    end
  end

  assign ins_slot = cmd_slot_en ? cmd_slot : (any_free ? free_idx : rr_idx);
  assign slot_ok  = int'(ins_slot) < N;

  always_comb begin
    lock_n = lock_v;
    if (slot_ok) lock_n[ins_slot] = cmd_data[LOCK_BIT];
  end

  always_comb begin
    valid_n = valid_q;
    used_n  = used_q;
    if (acc) begin
      case (cmd_op)
        OP_INS: begin
          valid_n = valid_n & ~cf_vec;
          used_n  = used_n & ~cf_vec;
          if (slot_ok) begin
            valid_n[ins_slot] = 1'b1;
            used_n[ins_slot]  = 1'b1;
          end
          if ($countones(used_n) == N) used_n = used_n & lock_n;
        end
        OP_DPG: begin valid_n = valid_n & ~pg_vec; used_n = used_n & ~pg_vec; end
        OP_DCX: begin valid_n = valid_n & ~cx_vec; used_n = used_n & ~cx_vec; end
        OP_DPT: begin valid_n = valid_n & ~pt_vec; used_n = used_n & ~pt_vec; end
        OP_INV: begin valid_n = '0; used_n = '0; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      used_q  <= '0;
      last_q  <= '0;
      rdy_q   <= 1'b0;
      inval_q <= 1'b0;
    end else begin
      valid_q <= valid_n;
      used_q  <= used_n;
      rdy_q   <= 1'b1;
      inval_q <= acc && cmd_op <= OP_INV;
      if (acc && cmd_op == OP_INS && !cmd_slot_en && !any_free && rr_found)
        last_q <= rr_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (acc && cmd_op == OP_INS && slot_ok) begin
      e_va[ins_slot]   <= cmd_va;
      e_part[ins_slot] <= cmd_part;
      e_ctx[ins_slot]  <= cmd_ctx;
      e_real[ins_slot] <= cmd_real;
      e_sz[ins_slot]   <= cmd_size;
      e_data[ins_slot] <= cmd_data;
    end
  end

  always_comb begin
    dg_tag  = '1;
    dg_data = '1;
    dg_used = 1'b0;
    if (int'(dg_idx) < N && valid_q[dg_idx]) begin
      dg_tag  = {e_part[dg_idx], e_real[dg_idx], 1'b0, ~e_sz[dg_idx],
                 e_va[dg_idx] | {43'd0, e_ctx[dg_idx]}};
      dg_data = e_data[dg_idx];
      dg_used = used_q[dg_idx];
    end
  end
endmodule

// File: rtl/lockaware_xlate_buf_chk.sv
module lockaware_xlate_buf_chk #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [2:0]    cmd_op,
  input logic [N-1:0]  valid_q,
  input logic [N-1:0]  used_q,
  input logic [IW-1:0] dg_idx,
  input logic [63:0]   dg_tag,
  input logic [63:0]   dg_data,
  input logic          inval_pulse
);
  a_r12_pulse_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op <= 3'd4) |=> inval_pulse);

  a_r12_no_spurious_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready && cmd_op <= 3'd4) |=> !inval_pulse);

  a_r7_used_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (used_q & ~valid_q) == '0);

  a_r10_inval_all_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd4) |=> valid_q == '0);

  a_r2_insert_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd0) |=> valid_q != '0);

  a_r11_invalid_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(dg_idx) < N && !valid_q[dg_idx]) |-> (dg_tag == '1 && dg_data == '1));
endmodule

bind lockaware_xlate_buf lockaware_xlate_buf_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .valid_q(valid_q), .used_q(used_q), .dg_idx(dg_idx),
  .dg_tag(dg_tag), .dg_data(dg_data), .inval_pulse(inval_pulse)
);

// File: tb/tb_lockaware_xlate_buf.sv
`timescale 1ns/1ps
module tb_lockaware_xlate_buf;
  localparam int N = 4;
  localparam int IW = 2;
  localparam logic [63:0] LK = 64'h40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [55:0] cmd_va = '0;
  logic [2:0] cmd_part = '0;
  logic [12:0] cmd_ctx = '0;
  logic cmd_real = 1'b0;
  logic [2:0] cmd_size = '0;
  logic [63:0] cmd_data = '0;
  logic cmd_slot_en = 1'b0;
  logic [IW-1:0] cmd_slot = '0;
  logic [55:0] lk_va = '0;
  logic [2:0] lk_part = '0;
  logic [12:0] lk_ctx = '0;
  logic lk_real = 1'b0;
  logic lk_hit;
  logic [N-1:0] lk_hit_vec;
  logic [63:0] lk_data, dg_tag, dg_data;
  logic [IW-1:0] dg_idx = '0;
  logic dg_used, inval_pulse;

  int total = 0, fails = 0;
  bit done = 0;
  logic pulse_seen;

  always #4 clk = ~clk;

  lockaware_xlate_buf #(.N(N)) dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] tagw(input logic [2:0] p, input logic r, input logic [2:0] s,
                                       input logic [55:0] va, input logic [12:0] c);
    return {p, r, 1'b0, ~s, va | {43'd0, c}};
  endfunction

  function automatic logic [55:0] pg(input int n);
    return 56'(n) << 13;
  endfunction

  task automatic cmd(input logic [2:0] op, input logic [55:0] va, input logic [2:0] p,
                     input logic [12:0] c, input logic r, input logic [2:0] s,
                     input logic [63:0] d, input logic sen, input logic [IW-1:0] sl);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_va = va; cmd_part = p; cmd_ctx = c;
    cmd_real = r; cmd_size = s; cmd_data = d; cmd_slot_en = sen; cmd_slot = sl;
    @(negedge clk);
    cmd_valid = 0;
    pulse_seen = inval_pulse;
  endtask

  task automatic ins(input logic [55:0] va, input logic [2:0] p, input logic [12:0] c,
                     input logic [63:0] d);
    cmd(3'd0, va, p, c, 1'b0, 3'd0, d, 1'b0, '0);
  endtask

  task automatic peek(input int i);
    dg_idx = IW'(i);
    #1;
  endtask

  task automatic look(input logic [55:0] va, input logic [2:0] p, input logic [12:0] c, input logic r);
    lk_va = va; lk_part = p; lk_ctx = c; lk_real = r;
    #1;
  endtask

  task automatic t_reset;
    for (int i = 0; i < N; i++) begin
      peek(i);
      chk(dg_tag == '1 && dg_data == '1, "R1 reset slot empty", dg_tag, '1);
    end
    look(pg(1), 3'd1, 13'd5, 1'b0);
    chk(!lk_hit, "R1 no hit after reset", 64'(lk_hit), 0);
    chk(cmd_ready && !inval_pulse, "R1 ready high pulse low", {cmd_ready, inval_pulse}, 2'b10);
  endtask

  task automatic t_fill;
    for (int k = 0; k < 4; k++) begin
      ins(pg(k + 1), 3'd1, 13'd5, 64'h100 + 64'(k));
      peek(k);
      chk(dg_tag == tagw(3'd1, 1'b0, 3'd0, pg(k + 1), 13'd5), "R2 lowest free slot tag",
          dg_tag, tagw(3'd1, 1'b0, 3'd0, pg(k + 1), 13'd5));
      if (k == 2) chk(dg_used, "R2 new entry used", 64'(dg_used), 1);
    end
    peek(0);
    chk(!dg_used, "R7 aging clears unlocked", 64'(dg_used), 0);
    look(pg(3) + 56'h123, 3'd1, 13'd5, 1'b0);
    chk(lk_hit_vec == 4'b0100 && lk_data == 64'h102, "R8 lookup hit slot2", {lk_hit_vec, lk_data[59:0]}, {4'b0100, 60'h102});
  endtask

  task automatic t_replace;
    ins(pg(10), 3'd1, 13'd5, 64'h200);
    peek(1);
    chk(dg_data == 64'h200, "R5 victim after last", dg_data, 64'h200);
    ins(pg(11), 3'd1, 13'd5, 64'h201);
    peek(2);
    chk(dg_data == 64'h201, "R5 victim advances", dg_data, 64'h201);
    cmd(3'd0, pg(12), 3'd1, 13'd5, 1'b0, 3'd0, 64'h202 | LK, 1'b1, 2'd3);
    peek(3);
    chk(dg_data == (64'h202 | LK), "R4 explicit slot", dg_data, 64'h202 | LK);
    ins(pg(13), 3'd1, 13'd5, 64'h203);
    peek(0);
    chk(dg_data == 64'h203, "R5 skips locked and wraps", dg_data, 64'h203);
    chk(!dg_used, "R7 unlocked aged", 64'(dg_used), 0);
    peek(3);
    chk(dg_used, "R7 locked keeps used", 64'(dg_used), 1);
  endtask

  task automatic t_conflict;
    ins(pg(11), 3'd1, 13'd5, 64'h301);
    peek(2);
    chk(dg_data == 64'h301, "R3 conflict slot reused", dg_data, 64'h301);
    look(pg(11), 3'd1, 13'd5, 1'b0);
    chk(lk_hit_vec == 4'b0100, "R3 single match", 64'(lk_hit_vec), 4);
    ins(pg(14), 3'd1, 13'd5, 64'h302);
    peek(1);
    chk(dg_data == 64'h302, "R5 last index kept by free insert", dg_data, 64'h302);
  endtask

  task automatic t_demaps;
    cmd(3'd1, pg(13) + 56'h55, 3'd1, 13'd5, 1'b0, 3'd0, '0, 1'b0, '0);
    peek(0);
    chk(dg_tag == '1, "R9 demap page", dg_tag, '1);
    look(pg(13), 3'd1, 13'd5, 1'b0);
    chk(!lk_hit, "R9 miss after demap", 64'(lk_hit), 0);
    ins(pg(20), 3'd1, 13'd9, 64'h400);
    cmd(3'd2, '0, 3'd1, 13'd5, 1'b0, 3'd0, '0, 1'b0, '0);
    peek(3);
    chk(dg_tag == '1, "R10 context demap hits locked", dg_tag, '1);
    peek(0);
    chk(dg_data == 64'h400, "R10 other context kept", dg_data, 64'h400);
    ins(pg(30), 3'd2, 13'd5, 64'h500 | LK);
    ins(pg(31), 3'd2, 13'd5, 64'h501);
    cmd(3'd3, '0, 3'd2, 13'd0, 1'b0, 3'd0, '0, 1'b0, '0);
    peek(1);
    chk(dg_data == (64'h500 | LK), "R10 partition demap keeps locked", dg_data, 64'h500 | LK);
    peek(2);
    chk(dg_tag == '1, "R10 partition demap unlocked", dg_tag, '1);
    peek(0);
    chk(dg_data == 64'h400, "R10 other partition kept", dg_data, 64'h400);
    cmd(3'd4, '0, '0, '0, 1'b0, 3'd0, '0, 1'b0, '0);
    peek(1);
    chk(dg_tag == '1 && !dg_used, "R10 invalidate all locked", dg_tag, '1);
  endtask

  task automatic t_all_locked;
    for (int k = 0; k < 4; k++) ins(pg(40 + k), 3'd0, 13'd1, (64'h600 + 64'(k)) | LK);
    ins(pg(44), 3'd0, 13'd1, 64'h700 | LK);
    peek(3);
    chk(dg_tag == tagw(3'd0, 1'b0, 3'd0, pg(44), 13'd1), "R6 all locked uses last slot",
        dg_tag, tagw(3'd0, 1'b0, 3'd0, pg(44), 13'd1));
    peek(0);
    chk(dg_used && dg_data == (64'h600 | LK), "R7 locked not aged", {63'd0, dg_used}, 1);
  endtask

  task automatic t_real_size;
    cmd(3'd4, '0, '0, '0, 1'b0, 3'd0, '0, 1'b0, '0);
    cmd(3'd0, 56'h40000, 3'd0, 13'd3, 1'b1, 3'd1, 64'h800, 1'b0, '0);
    peek(0);
    chk(dg_tag == tagw(3'd0, 1'b1, 3'd1, 56'h40000, 13'd3), "R11 tag layout",
        dg_tag, tagw(3'd0, 1'b1, 3'd1, 56'h40000, 13'd3));
    look(56'h4E123, 3'd0, 13'd7, 1'b1);
    chk(lk_hit && lk_data == 64'h800, "R8 real ignores context, large page", lk_data, 64'h800);
    look(56'h50000, 3'd0, 13'd3, 1'b1);
    chk(!lk_hit, "R8 outside page", 64'(lk_hit), 0);
    look(56'h40000, 3'd0, 13'd3, 1'b0);
    chk(!lk_hit, "R8 real flag must match", 64'(lk_hit), 0);
  endtask

  task automatic t_pulse;
    ins(pg(50), 3'd0, 13'd0, 64'h900);
    chk(pulse_seen, "R12 pulse after insert", 64'(pulse_seen), 1);
    @(negedge clk);
    chk(!inval_pulse, "R12 pulse one cycle", 64'(inval_pulse), 0);
    cmd(3'd6, '0, '0, '0, 1'b0, 3'd0, '0, 1'b0, '0);
    chk(!pulse_seen, "R12 unused op no pulse", 64'(pulse_seen), 0);
    peek(0);
    chk(dg_data == 64'h800, "R12 unused op no effect", dg_data, 64'h800);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_fill();
    t_replace();
    t_conflict();
    t_demaps();
    t_all_locked();
    t_real_size();
    t_pulse();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule